// File: doc/BRIEF.md
# Framing-Clock Deserializer with Lane Deskew Training

This block sits behind a set of sampled serial lanes. Each data lane carries seven bits per parallel word. One further lane carries a framing clock whose rising transition marks where a word starts. The block runs on the bit clock. It rebuilds the parallel word, puts out a parallel clock whose rising edge falls in the middle of stable data, and detects when the framing lane stops toggling.

A per-lane skew stage can delay each data lane by zero, one or two bit times. Relative to a reference lane, that corrects an offset of minus one, zero or plus one bit. The choice is made by a training controller that watches switching traffic carrying the same pattern on every lane. For each lane it counts how often each delay choice agrees with lane 0. Training starts by itself after reset. It starts again after a low pulse of sufficient length on the deskew control input. It finishes only after an unbroken run of words in which every lane switched.

Top module: `fcd_deserializer`

## Requirements
- R1: A word is framed by a 0-to-1 change of the framing lane. The framing lane is high for the first four bits of a word and low for the last three. The bit received at position p (0..6) on data lane i appears at `word_out[i*7+p]`.
- R2: `word_out` changes at most once per word. `pclk_out` rises at word position 2 and is high for positions 2 to 4, so `word_out` is stable whenever `pclk_out` rises.
- R3: After reset the block trains without any request, and `deskew_done` stays low while it trains.
- R4: A word counts as valid when every data lane shows at least one transition between consecutive bit samples inside that word. `deskew_done` rises after the 4096th consecutive valid word.
- R5: A word in which any lane does not switch sets the valid-word run back to zero and discards the agreement counts gathered so far.
- R6: `deskew_n` held low for at least 4 bit clocks and then driven high restarts training and clears `deskew_done`. A low pulse shorter than 4 clocks has no effect.
- R7: Each lane selects a delay of 0, 1 or 2 bits (offset +1, 0, -1 relative to lane 0, which always uses delay 1). The selected delay is the one whose samples agreed most often with lane 0 during training. A tie goes to delay 1. After training, lanes arriving one bit early or late are delivered aligned.
- R8: Once training completes, the selected delays do not change until the next training run starts.
- R9: After 16 bit clocks with no change on the framing lane, `link_idle` goes high, `pclk_out` is held low and `word_out` holds its last value.
- R10: During and right after reset, `word_out` is zero, `pclk_out` and `deskew_done` are low, and `link_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_in | input | 1 | Sampled framing-clock lane |
| lane_in | input | LANES (4) | Sampled serial data lanes |
| deskew_n | input | 1 | Active-low training request; takes effect on release |
| word_out | output | LANES*7 (28) | Rebuilt parallel word |
| pclk_out | output | 1 | Recovered parallel clock |
| deskew_done | output | 1 | High once training has fixed the lane delays |
| link_idle | output | 1 | High while no framing activity is seen |

## Verification
The bench skews lanes by one bit early and one bit late, both before and after a retraining with a different skew set. A wrong tap choice or a tie broken away from the centre therefore shows up as scrambled bits in `word_out`. It breaks a training run with a few words of a frozen lane. A design that only counted total valid words, instead of consecutive ones, would raise `deskew_done` too early. It sends a three-clock request pulse, which must leave the calibration intact. It stops the framing lane to check that `pclk_out` parks low and the last word is held rather than cleared or overwritten.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef logic [1:0] tap_t;

  localparam tap_t TAP_CENTRE = 2'd1;

  // Choose the delay with the most agreements; centre wins ties, then delay 0.
  function automatic tap_t pick_tap(input int unsigned agree0,
                                    input int unsigned agree1,
                                    input int unsigned agree2);
    if (agree1 >= agree0 && agree1 >= agree2) return TAP_CENTRE;
    if (agree0 >= agree2) return 2'd0;
    return 2'd2;
  endfunction

  // Parallel clock is high on the three positions around mid-word.
  function automatic logic pclk_phase(input int unsigned pos,
                                      input int unsigned wbits);
    return (pos + 1 >= wbits / 2) && (pos <= wbits / 2 + 1);
  endfunction

endpackage

// File: rtl/fcd_frame_track.sv
module fcd_frame_track #(
  parameter int WB        = 7,
  parameter int IDLE_BITS = 16,
  localparam int PW = $clog2(WB),
  localparam int CW = $clog2(IDLE_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_in,
  output logic [PW-1:0] pos,
  output logic          word_end,
  output logic          idle,
  output logic          pclk
);
  import fcd_pkg::*;

  logic [2:0]    fh;
  logic [PW-1:0] pos_q;
  logic [CW-1:0] quiet_q;
  logic          wstart;

  assign wstart   = fh[1] & ~fh[2];
  assign pos      = wstart ? '0 : pos_q;
  assign word_end = (pos == PW'(WB - 1));
  assign idle     = (quiet_q == CW'(IDLE_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fh      <= '0;
      pos_q   <= '0;
      quiet_q <= CW'(IDLE_BITS);
      pclk    <= 1'b0;
    end else begin
      fh    <= {fh[1:0], frame_in};
      pos_q <= word_end ? '0 : pos + 1'b1;
      if (fh[0] ^ fh[1])  quiet_q <= '0;
      else if (!idle)     quiet_q <= quiet_q + 1'b1;
      pclk  <= idle ? 1'b0 : pclk_phase(32'(pos), WB);
    end
  end

endmodule

// File: rtl/fcd_lane_align.sv
module fcd_lane_align #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  fcd_pkg::tap_t tap,
  input  logic [PW-1:0] pos,
  output logic          bit_al,
  output logic [2:0]    hist,
  output logic          seen
);
  logic [2:0] h;
  logic       tog_q;

  assign hist = h;
  assign seen = (h[0] ^ h[1]) | ((pos != '0) & tog_q);

  always_comb begin
    case (tap)
      2'd0:    bit_al = h[0];
      2'd2:    bit_al = h[2];
      default: bit_al = h[1];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h     <= '0;
      tog_q <= 1'b0;
    end else begin
      h     <= {h[1:0], din};
      tog_q <= seen;
    end
  end

endmodule

// File: rtl/fcd_trainer.sv
module fcd_trainer #(
  parameter int LANES       = 4,
  parameter int WB          = 7,
  parameter int TRAIN_WORDS = 4096,
  parameter int MIN_PULSE   = 4,
  localparam int MW = $clog2(TRAIN_WORDS * WB + WB + 1),
  localparam int VW = $clog2(TRAIN_WORDS + 1),
  localparam int LW = $clog2(MIN_PULSE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               deskew_n,
  input  logic               word_end,
  input  logic               all_seen,
  input  logic [LANES*3-1:0] hist,
  output logic [LANES*2-1:0] taps,
  output logic               done,
  output logic               training,
  output logic               start
);
  import fcd_pkg::*;

  logic [MW-1:0] agree_q [LANES][3];
  tap_t          tap_q   [LANES];
  logic [VW-1:0] run_q;
  logic [LW-1:0] low_q;
  logic          dsk_q;
  logic          ref_bit;

  assign ref_bit = hist[1];
  assign start   = deskew_n & ~dsk_q & (low_q == LW'(MIN_PULSE));

  for (genvar g = 0; g < LANES; g++) begin : g_taps
    assign taps[g*2 +: 2] = tap_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsk_q <= 1'b1;
      low_q <= '0;
    end else begin
      dsk_q <= deskew_n;
      if (deskew_n)                   low_q <= '0;
      else if (low_q != LW'(MIN_PULSE)) low_q <= low_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      training <= 1'b1;
      done     <= 1'b0;
      run_q    <= '0;
      for (int i = 0; i < LANES; i++) begin
        tap_q[i] <= TAP_CENTRE;
        for (int t = 0; t < 3; t++) agree_q[i][t] <= '0;
      end
    end else if (start) begin
      training <= 1'b1;
      done     <= 1'b0;
      run_q    <= '0;
      for (int i = 0; i < LANES; i++)
        for (int t = 0; t < 3; t++) agree_q[i][t] <= '0;
    end else if (training) begin
      for (int i = 0; i < LANES; i++)
        for (int t = 0; t < 3; t++)
          agree_q[i][t] <= agree_q[i][t] + MW'(hist[i*3+t] == ref_bit);
      if (word_end) begin
        if (!all_seen) begin
          run_q <= '0;
          for (int i = 0; i < LANES; i++)
            for (int t = 0; t < 3; t++) agree_q[i][t] <= '0;
        end else if (run_q == VW'(TRAIN_WORDS - 1)) begin
          training <= 1'b0;
          done     <= 1'b1;
          for (int i = 0; i < LANES; i++)
            tap_q[i] <= pick_tap(32'(agree_q[i][0]), 32'(agree_q[i][1]),
                                 32'(agree_q[i][2]));
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fcd_assemble.sv
module fcd_assemble #(
  parameter int LANES = 4,
  parameter int WB    = 7,
  localparam int PW = $clog2(WB),
  localparam int DW = LANES * WB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] bits,
  input  logic [PW-1:0]    pos,
  input  logic             word_end,
  input  logic             idle,
  output logic [DW-1:0]    word
);
  logic [DW-1:0] asm_q;
  logic [DW-1:0] asm_nxt;

  always_comb begin
    asm_nxt = asm_q;
    for (int i = 0; i < LANES; i++)
      asm_nxt[i*WB + 32'(pos)] = bits[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
      word  <= '0;
    end else if (!idle) begin
      asm_q <= asm_nxt;
      if (word_end) word <= asm_nxt;
    end
  end

endmodule

// File: rtl/fcd_deserializer.sv
module fcd_deserializer #(
  parameter int LANES       = 4,
  parameter int WB          = 7,
  parameter int TRAIN_WORDS = 4096,
  parameter int MIN_PULSE   = 4,
  parameter int IDLE_BITS   = 16,
  localparam int PW = $clog2(WB),
  localparam int DW = LANES * WB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_in,
  input  logic [LANES-1:0] lane_in,
  input  logic             deskew_n,
  output logic [DW-1:0]    word_out,
  output logic             pclk_out,
  output logic             deskew_done,
  output logic             link_idle
);
  logic [PW-1:0]      pos;
  logic               word_end;
  logic               idle;
  logic [LANES-1:0]   bits_al;
  logic [LANES-1:0]   seen;
  logic [LANES*3-1:0] hist;
  logic [LANES*2-1:0] taps;
  logic               training;
  logic               start;

  assign link_idle = idle;

  fcd_frame_track #(.WB(WB), .IDLE_BITS(IDLE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in),
    .pos(pos), .word_end(word_end), .idle(idle), .pclk(pclk_out)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fcd_lane_align #(.PW(PW)) u_align (
      .clk(clk), .rst_n(rst_n), .din(lane_in[g]), .tap(taps[g*2 +: 2]),
      .pos(pos), .bit_al(bits_al[g]), .hist(hist[g*3 +: 3]), .seen(seen[g])
    );
  end

  fcd_trainer #(.LANES(LANES), .WB(WB), .TRAIN_WORDS(TRAIN_WORDS),
                .MIN_PULSE(MIN_PULSE)) u_train (
    .clk(clk), .rst_n(rst_n), .deskew_n(deskew_n), .word_end(word_end),
    .all_seen(&seen), .hist(hist), .taps(taps), .done(deskew_done),
    .training(training), .start(start)
  );

  fcd_assemble #(.LANES(LANES), .WB(WB)) u_asm (
    .clk(clk), .rst_n(rst_n), .bits(bits_al), .pos(pos),
    .word_end(word_end), .idle(idle), .word(word_out)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int LANES = 4,
  parameter int WB    = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               idle,
  input logic               pclk,
  input logic [LANES*WB-1:0] word,
  input logic               done,
  input logic               training,
  input logic               start,
  input logic [LANES*2-1:0] taps
);
  p_idle_clk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !pclk);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(word));

  p_pclk_on_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pclk) |-> $stable(word));

  p_taps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !training |=> $stable(taps));

  p_restart_clears_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && training));

  p_done_from_training_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(training));

  p_no_done_while_training_r3: assert property (@(posedge clk) disable iff (!rst_n)
    training |-> !done);

  for (genvar g = 0; g < LANES; g++) begin : g_tap
    p_tap_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      taps[g*2 +: 2] != 2'd3);
  end
endmodule

bind fcd_deserializer fcd_checker #(.LANES(LANES), .WB(WB)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .pclk(pclk_out), .word(word_out),
  .done(deskew_done), .training(training), .start(start), .taps(taps)
);

// File: tb/tb_fcd_deserializer.sv
module tb_fcd_deserializer;
  localparam int LANES = 4;
  localparam int WB    = 7;
  localparam int DW    = LANES * WB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_in = 1'b0;
  logic [LANES-1:0] lane_in = '0;
  logic          deskew_n = 1'b1;
  logic [DW-1:0] word_out;
  logic          pclk_out;
  logic          deskew_done;
  logic          link_idle;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int  n = 0;
  bit  train_m = 1;
  bit  idle_m  = 0;
  int  stuck   = -1;
  int  skew [LANES] = '{0, 1, -1, 0};
  bit  chk_en = 0;
  bit  locked = 0;
  int  lat    = 0;
  logic pclk_prev = 1'b0;

  always #2 clk = ~clk;

  fcd_deserializer dut (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .lane_in(lane_in),
    .deskew_n(deskew_n), .word_out(word_out), .pclk_out(pclk_out),
    .deskew_done(deskew_done), .link_idle(link_idle)
  );

  function automatic bit hb(input int unsigned x);
    int unsigned y;
    y = x * 32'h9E3779B1;
    y ^= y >> 16;
    y *= 32'h85EBCA6B;
    y ^= y >> 13;
    return y[7];
  endfunction

  function automatic bit norm_bit(input int lane, input int k);
    if (k < 0) return 1'b0;
    return hb(32'(k) * 4 + 32'(lane) + 1000);
  endfunction

  function automatic bit tx_bit(input int lane, input int k);
    if (k < 0) return 1'b0;
    if (train_m) return (k % WB == 3) ? ~hb(32'(k - 1)) : hb(32'(k));
    return norm_bit(lane, k);
  endfunction

  function automatic logic [DW-1:0] exp_word(input int w);
    logic [DW-1:0] e;
    for (int i = 0; i < LANES; i++)
      for (int p = 0; p < WB; p++) e[i*WB+p] = norm_bit(i, w*WB + p);
    return e;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bit time: observe outputs, then drive the next bit on every lane.
  task automatic step();
    @(negedge clk);
    if (chk_en && pclk_out && !pclk_prev) begin
      if (!locked) begin
        int found = -1;
        for (int w = n / WB; w >= n / WB - 6; w--)
          if (found < 0 && word_out == exp_word(w)) found = w;
        check(found >= 0, "R1/R7 word lock", 64'(word_out), 64'(exp_word(n / WB - 1)));
        if (found >= 0) begin
          locked = 1;
          lat = n / WB - found;
        end
      end else begin
        check(word_out == exp_word(n / WB - lat), "R7 aligned word",
              64'(word_out), 64'(exp_word(n / WB - lat)));
      end
    end
    pclk_prev = pclk_out;
    if (idle_m) begin
      frame_in = 1'b1;
      lane_in  = '0;
    end else begin
      frame_in = (n % WB) < 4;
      for (int i = 0; i < LANES; i++)
        lane_in[i] = (i == stuck) ? 1'b0 : tx_bit(i, n - skew[i]);
    end
    n++;
  endtask

  task automatic run_bits(input int k);
    for (int j = 0; j < k; j++) step();
  endtask

  task automatic run_words(input int k);
    run_bits(k * WB);
  endtask

  task automatic data_phase(input int words);
    train_m = 0;
    run_words(20);
    chk_en = 1;
    run_words(words);
    chk_en = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    check(word_out == '0, "R10 word_out reset", 64'(word_out), 64'd0);
    check(!pclk_out && !deskew_done, "R10 pclk/done reset",
          64'({pclk_out, deskew_done}), 64'd0);
    check(link_idle == 1'b1, "R10 link_idle reset", 64'(link_idle), 64'd1);
    rst_n = 1'b1;

    // R3/R4: automatic training after reset
    train_m = 1;
    run_words(4000);
    check(!deskew_done, "R3 done low while training", 64'(deskew_done), 64'd0);
    run_words(110);
    check(deskew_done, "R4 done after 4096 valid words", 64'(deskew_done), 64'd1);
    data_phase(60);

    // R6: full request pulse, new skew set
    skew = '{0, -1, 1, 1};
    train_m = 1;
    deskew_n = 1'b0;
    run_bits(6);
    deskew_n = 1'b1;
    run_bits(3);
    check(!deskew_done, "R6 request clears done", 64'(deskew_done), 64'd0);

    // R5: frozen lane breaks the run
    run_words(2000);
    stuck = 2;
    run_words(3);
    stuck = -1;
    run_words(4000);
    check(!deskew_done, "R5 run restarted by frozen lane", 64'(deskew_done), 64'd0);
    run_words(200);
    check(deskew_done, "R4 done after retraining", 64'(deskew_done), 64'd1);
    data_phase(60);

    // R6/R8: short pulse ignored, delays kept
    deskew_n = 1'b0;
    run_bits(3);
    deskew_n = 1'b1;
    run_bits(10);
    check(deskew_done, "R6 short pulse ignored", 64'(deskew_done), 64'd1);
    data_phase(40);

    // R9: framing lane stops
    idle_m = 1;
    run_bits(20);
    held = word_out;
    run_bits(20);
    check(link_idle, "R9 link_idle high", 64'(link_idle), 64'd1);
    check(!pclk_out, "R9 pclk parked low", 64'(pclk_out), 64'd0);
    check(word_out == held, "R9 word held", 64'(word_out), 64'(held));
    idle_m = 0;
    run_bits(3);
    check(!link_idle, "R9 idle clears on activity", 64'(link_idle), 64'd0);
    data_phase(40);
    check(deskew_done, "R8 done kept over idle", 64'(deskew_done), 64'd1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule